// File: doc/BRIEF.md
# Serial ADC Conversion Read Controller

This block is the host-side master for a three-wire serial sampling converter. It drives a sample-start pulse and a serial clock toward the converter and shifts the returned serial data into a parallel word. One frame is one conversion. A frame opens with a sample-start pulse that lasts one serial clock period. The converter then shifts out its result, most significant bit first, starting after the third serial clock rising edge of the frame. The controller samples each bit at the serial clock falling edge.

The serial clock is derived from the system clock by an even division ratio `SCK_DIV`. The result width `RES_W` is set at build time to 12 or 14. The frame length is 16 serial clock periods, or 18 when `EXTRA_ACQ` is set. The two extra periods give the converter its acquisition time at full rate. Frames run either one at a time on a start request or back to back while continuous mode is held. Each result is presented right-aligned in a 16-bit word with a one-cycle valid strobe.

The sequencer has four states. `ST_IDLE` waits for a request. `ST_LEAD` covers serial periods 0 and 1: the sample-start pulse and the converter's lead-in. `ST_SHIFT` covers the data periods 2 to `RES_W+1`. `ST_TAIL` covers the periods left in the frame. The transitions are:
- idle-to-lead, on start or continuous mode.
- lead-to-shift, at the end of period 1.
- shift-to-tail, after the last data period when the frame is longer.
- shift-or-tail wrap, at the end of the last period: to lead when continuous mode is high, otherwise to idle.

Top module: `adc_serial_reader`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `smp_start_o`, `ser_clk_o` and `valid_o` are 0 and `result_o` is all zeros.
- R2: A `start_i` high at a clock edge while idle opens a frame. `smp_start_o` is high from the next cycle for exactly `SCK_DIV` cycles (one serial period). `ser_clk_o` is low in the cycle where `smp_start_o` rises.
- R3: Each serial period lasts `SCK_DIV` system cycles. `ser_clk_o` is low for the first `SCK_DIV/2` cycles and high for the rest. A frame has 16 serial periods when `EXTRA_ACQ`=0 and 18 when `EXTRA_ACQ`=1. `ser_clk_o` stays low while idle.
- R4: `ser_din_i` is sampled at the system edge where `ser_clk_o` falls, which is the end of each serial period. Samples ending periods 0 and 1, and any after period `RES_W+1`, are discarded. The samples ending periods 2 to `RES_W+1` (periods numbered from 0 at the pulse) form the result, and the first of them is the MSB.
- R5: `valid_o` is high for exactly one cycle. Counting the edge that accepted the frame as edge 0, it is high in the cycle that follows edge `(RES_W+2)*SCK_DIV`. In that cycle `result_o[RES_W-1:0]` holds the word and `result_o[15:RES_W]` is zero.
- R6: `result_o` changes only in a cycle where `valid_o` is high, and holds its value until the next one.
- R7: A `start_i` pulse during a frame, including the frame's last cycle, is ignored. No extra pulse appears, the frame keeps its length, and the block goes idle at the end of the frame.
- R8: If `cont_i` is high at the frame's final edge, the next frame starts at once: `smp_start_o` rises `FRAME*SCK_DIV` cycles after the previous rise. If `cont_i` is low at that edge, the block goes idle and its outputs stay low.
- R9: A `cont_i` high while idle opens a frame exactly as `start_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one frame (accepted only while idle) |
| cont_i | input | 1 | Continuous mode: keep running frames back to back |
| ser_din_i | input | 1 | Serial data from the converter |
| smp_start_o | output | 1 | Sample-start pulse, one serial period wide |
| ser_clk_o | output | 1 | Serial clock toward the converter |
| result_o | output | 16 | Right-aligned result word, zero-filled above `RES_W` |
| valid_o | output | 1 | One-cycle strobe marking a new `result_o` |

## Verification
Every output is due at a fixed cycle offset n from the edge that accepts a request. Cycle n=1 is the one after that edge. The sample-start pulse occupies n=1..SCK_DIV of each frame. The serial clock is high when `(n-1) mod SCK_DIV >= SCK_DIV/2`. The valid strobe lands at `n = f*FRAME*SCK_DIV + (RES_W+2)*SCK_DIV + 1` for frame f. The bench samples every cycle at the falling system edge and compares each output with these arithmetic expectations. A converter model returns a known word per frame and puts ones on the discarded bit slots. Two configurations (14 bits, 16 periods, divide by 4; and 12 bits, 18 periods, divide by 2) run single, poked and continuous frames.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL
    } rd_state_e;

    localparam int BASE_PERIODS  = 16;
    localparam int ACQ_PERIODS   = 2;
    localparam int LEAD_PERIODS  = 2;

    function automatic int frame_periods(input bit extra_acq);
        return BASE_PERIODS + (extra_acq ? ACQ_PERIODS : 0);
    endfunction

endpackage

// File: rtl/adc_rd_timebase.sv
module adc_rd_timebase #(
    parameter int SCK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_end,
    output logic sck_hi
);
    localparam int PH_W = (SCK_DIV > 2) ? $clog2(SCK_DIV) : 1;
    localparam int HALF = SCK_DIV / 2;

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || phase_end) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign phase_end = run && (phase_q == PH_W'(SCK_DIV - 1));
    assign sck_hi    = run && (phase_q >= PH_W'(HALF));

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
    parameter int RES_W = 14,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             last,
    input  logic             sdin,
    output logic [OUT_W-1:0] result,
    output logic             valid
);
    logic [RES_W-2:0] sh_q;
    logic [RES_W-1:0] word_w;

    assign word_w = {sh_q, sdin};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (take) begin
                sh_q <= word_w[RES_W-2:0];
                if (last) begin
                    result <= OUT_W'(word_w);
                    valid  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
    import adc_rd_pkg::*;
#(
    parameter int RES_W     = 14,
    parameter bit EXTRA_ACQ = 1'b0,
    parameter int SCK_DIV   = 4,
    parameter int OUT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic             ser_din_i,
    output logic             smp_start_o,
    output logic             ser_clk_o,
    output logic [OUT_W-1:0] result_o,
    output logic             valid_o
);
    localparam int FRAME_P   = frame_periods(EXTRA_ACQ);
    localparam int PER_W     = $clog2(FRAME_P);
    localparam int LAST_DATA = LEAD_PERIODS + RES_W - 1;

    rd_state_e        st_q, st_d;
    logic [PER_W-1:0] period_q, period_d;
    logic             phase_end;
    logic             sck_hi;
    logic             frame_end;
    logic             take;
    logic             last_bit;

    adc_rd_timebase #(.SCK_DIV(SCK_DIV)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (st_q != ST_IDLE),
        .phase_end (phase_end),
        .sck_hi    (sck_hi)
    );

    assign frame_end = phase_end && (period_q == PER_W'(FRAME_P - 1));
    assign take      = (st_q == ST_SHIFT) && phase_end;
    assign last_bit  = (period_q == PER_W'(LAST_DATA));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            period_q <= '0;
        end else begin
            st_q     <= st_d;
            period_q <= period_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d     = st_q;
        period_d = period_q;
        unique case (st_q)
            ST_IDLE: begin
                period_d = '0;
                if (start_i || cont_i) begin
                    st_d = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (phase_end) begin
                    period_d = period_q + 1'b1;
                    if (period_q == PER_W'(LEAD_PERIODS - 1)) begin
                        st_d = ST_SHIFT;
                    end
                end
            end
            ST_SHIFT: begin
                if (frame_end) begin
                    period_d = '0;
                    st_d     = cont_i ? ST_LEAD : ST_IDLE;
                end else if (phase_end) begin
                    period_d = period_q + 1'b1;
                    if (last_bit) begin
                        st_d = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (frame_end) begin
                    period_d = '0;
                    st_d     = cont_i ? ST_LEAD : ST_IDLE;
                end else if (phase_end) begin
                    period_d = period_q + 1'b1;
                end
            end
            default: begin
                st_d     = ST_IDLE;
                period_d = '0;
            end
        endcase
    end

    // Output decode
    always_comb begin
        smp_start_o = (st_q == ST_LEAD) && (period_q == '0);
        ser_clk_o   = sck_hi;
    end

    adc_rd_capture #(.RES_W(RES_W), .OUT_W(OUT_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .last   (last_bit),
        .sdin   (ser_din_i),
        .result (result_o),
        .valid  (valid_o)
    );

endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker #(
    parameter int RES_W   = 14,
    parameter int OUT_W   = 16,
    parameter int SCK_DIV = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_start_o,
    input logic             ser_clk_o,
    input logic [OUT_W-1:0] result_o,
    input logic             valid_o
);
    logic        start_q, clk_q, seen_q;
    logic [7:0]  rise_cnt;
    logic [15:0] high_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= 1'b0;
            clk_q    <= 1'b0;
            seen_q   <= 1'b0;
            rise_cnt <= '0;
            high_cnt <= '0;
        end else begin
            start_q <= smp_start_o;
            clk_q   <= ser_clk_o;
            if (smp_start_o && !start_q) begin
                rise_cnt <= '0;
                seen_q   <= 1'b1;
            end else if (ser_clk_o && !clk_q && rise_cnt != 8'hFF) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
            high_cnt <= smp_start_o ? high_cnt + 1'b1 : '0;
        end
    end

    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((result_o >> RES_W) == '0));

    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> valid_o);

    a_r2_start_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smp_start_o) |-> !ser_clk_o);

    a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_start_o && start_q) |-> (high_cnt == 16'(SCK_DIV)));

    a_r3_min_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_start_o && !start_q && seen_q) |-> (rise_cnt >= 8'd16));

endmodule

bind adc_serial_reader adc_rd_checker #(
    .RES_W   (RES_W),
    .OUT_W   (OUT_W),
    .SCK_DIV (SCK_DIV)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_start_o (smp_start_o),
    .ser_clk_o   (ser_clk_o),
    .result_o    (result_o),
    .valid_o     (valid_o)
);

// File: tb/tb_adc_serial_reader.sv
`timescale 1ns/1ps

module tb_adc_harness #(
    parameter int    RES_W     = 14,
    parameter bit    EXTRA_ACQ = 1'b0,
    parameter int    SCK_DIV   = 4,
    parameter string TAG       = "A"
) (
    input  logic clk,
    input  logic rst_n,
    output logic done,
    output int   n_chk,
    output int   n_bad
);
    localparam int OUT_W = 16;
    localparam int FP    = 16 + (EXTRA_ACQ ? 2 : 0);
    localparam int FL    = FP * SCK_DIV;
    localparam int HALF  = SCK_DIV / 2;

    logic             start_i = 1'b0;
    logic             cont_i  = 1'b0;
    logic             ser_din = 1'b1;
    logic             smp_start_o, ser_clk_o, valid_o;
    logic [OUT_W-1:0] result_o;

    adc_serial_reader #(
        .RES_W(RES_W), .EXTRA_ACQ(EXTRA_ACQ), .SCK_DIV(SCK_DIV), .OUT_W(OUT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
        .ser_din_i(ser_din), .smp_start_o(smp_start_o), .ser_clk_o(ser_clk_o),
        .result_o(result_o), .valid_o(valid_o)
    );

    function automatic logic [RES_W-1:0] patt(input int i);
        logic [31:0] v;
        if (i == 0) return '0;
        if (i == 1) return '1;
        if (i == 2) return {(RES_W/2){2'b10}};
        v = (i * 32'h9E37) ^ 32'h5A5;
        return v[RES_W-1:0];
    endfunction

    // Converter model: one word per pulse, data after rising edges 3..RES_W+2
    int               m_idx  = 0;
    int               m_seen = 0;
    int               m_rise = 0;
    logic [RES_W-1:0] m_word = '0;

    always @(posedge smp_start_o) begin
        m_word = patt(m_idx);
        m_idx  = m_idx + 1;
    end

    always @(posedge ser_clk_o) begin
        if (m_seen != m_idx) begin
            m_seen = m_idx;
            m_rise = 0;
        end
        m_rise = m_rise + 1;
        if (m_rise >= 3 && m_rise <= RES_W + 2)
            ser_din <= m_word[RES_W - 1 - (m_rise - 3)];
        else
            ser_din <= 1'b1;
    end

    int               base = 0;
    logic [OUT_W-1:0] exp_res = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s [%s] got %0h exp %0h", req, what, TAG, got, exp);
        end
    endtask

    task automatic run_seq(input int nfr, input bit use_cont, input bit poke,
                           input string req_start);
        int  bc = 0, bs = 0, bv = 0, br = 0;
        longint gc = 0, ec = 0, gs = 0, es = 0, gv = 0, ev = 0, gr = 0, er = 0;
        if (use_cont) cont_i = 1'b1; else start_i = 1'b1;
        @(negedge clk);
        for (int n = 1; n <= nfr * FL + 4 * SCK_DIV; n++) begin
            int f   = (n - 1) / FL;
            int m   = (n - 1) % FL;
            bit inf = (f < nfr);
            bit ce  = inf && (m / SCK_DIV == 0);
            bit se  = inf && (m % SCK_DIV >= HALF);
            int k   = n - 1 - (RES_W + 2) * SCK_DIV;
            bit ve  = (k >= 0) && (k % FL == 0) && (k / FL < nfr);
            if (ve) exp_res = OUT_W'(patt(base + k / FL));
            if (smp_start_o !== ce) begin
                if (bc == 0) begin gc = smp_start_o; ec = ce; end
                bc++;
            end
            if (ser_clk_o !== se) begin
                if (bs == 0) begin gs = ser_clk_o; es = se; end
                bs++;
            end
            if (valid_o !== ve) begin
                if (bv == 0) begin gv = valid_o; ev = ve; end
                bv++;
            end
            if (result_o !== exp_res) begin
                if (br == 0) begin gr = result_o; er = exp_res; end
                br++;
            end
            if (use_cont && n == (nfr - 1) * FL + 2) cont_i = 1'b0;
            start_i = poke && (n == SCK_DIV + 3 || n == FL);
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(bc == 0, req_start, "sample-start pulse timing", gc, ec);
        chk(bs == 0, "R3", "serial clock waveform", gs, es);
        chk(bv == 0, "R5", "valid strobe timing", gv, ev);
        chk(br == 0, "R4/R6", "result word and hold", gr, er);
        base += nfr;
    endtask

    initial begin
        done  = 1'b0;
        n_chk = 0;
        n_bad = 0;
        @(negedge clk);
        chk(!smp_start_o && !ser_clk_o && !valid_o && result_o == '0,
            "R1", "outputs in reset", {smp_start_o, ser_clk_o, valid_o, result_o}, 0);
        wait (rst_n);
        @(negedge clk);
        chk(!smp_start_o && !ser_clk_o && !valid_o && result_o == '0,
            "R1", "outputs after reset", {smp_start_o, ser_clk_o, valid_o, result_o}, 0);
        run_seq(1, 1'b0, 1'b0, "R2");   // all-zero word
        run_seq(1, 1'b0, 1'b0, "R2");   // all-ones word
        run_seq(1, 1'b0, 1'b1, "R7");   // start pokes mid-frame and at last cycle
        run_seq(1, 1'b0, 1'b0, "R2");
        run_seq(3, 1'b1, 1'b0, "R8");   // back-to-back frames then idle
        run_seq(1, 1'b1, 1'b0, "R9");   // continuous request from idle
        run_seq(2, 1'b1, 1'b1, "R7");
        run_seq(1, 1'b0, 1'b0, "R2");
        done = 1'b1;
    end

endmodule

module tb_adc_serial_reader;
    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic done_a, done_b;
    int   chk_a, bad_a, chk_b, bad_b;

    always #2.5 clk = ~clk;

    tb_adc_harness #(.RES_W(14), .EXTRA_ACQ(1'b0), .SCK_DIV(4), .TAG("w14_f16"))
        u_a (.clk(clk), .rst_n(rst_n), .done(done_a), .n_chk(chk_a), .n_bad(bad_a));

    tb_adc_harness #(.RES_W(12), .EXTRA_ACQ(1'b1), .SCK_DIV(2), .TAG("w12_f18"))
        u_b (.clk(clk), .rst_n(rst_n), .done(done_b), .n_chk(chk_b), .n_bad(bad_b));

    initial begin
        int cyc   = 0;
        int total = 0;
        int bad   = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        while (!(done_a && done_b) && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        total = chk_a + chk_b;
        bad   = bad_a + bad_b;
        if (!(done_a && done_b)) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got %0d cycles exp completion", cyc);
        end
        $display("%0d/%0d checks passed", total - bad, total);
        $finish;
    end

endmodule